// File: doc/BRIEF.md
# Bitfield-Capable Macro Execution Unit

This block is the arithmetic core of a small command-processing engine. Each cycle it decodes one 32-bit instruction word and combines two 32-bit operands into a result. It offers register-to-register arithmetic and logic, an add with an immediate, three bitfield operations and an immediate-offset read. The read forms an address for an external register file and passes the returned word through as the result. The only state inside the block is a carry flag. The arithmetic sub-operations update it, and add-with-carry and subtract-with-borrow consume it.

The surrounding sequencer supplies the instruction word, the operands and the read data. It pulses `issue` on each cycle in which the instruction really executes, and it takes `result` away to wherever it routes results. The unit does not sequence instructions and does not write any result register.

Top module: `bfx_alu`

## Requirements
- R1: While `rst` is high at a clock edge, the carry flag is cleared, so `carry_q` reads 0 after reset.
- R2: Instruction bits [2:0] choose the function: 0 register arithmetic/logic, 1 add immediate, 2 field replace, 3 field extract shifted by an immediate amount, 4 field extract shifted by a register amount, 5 immediate-offset read. Codes 6 and 7 are illegal: `illegal_op` goes to 1, `result` is 0 and the carry is not written.
- R3: With code 0, the sub-operation in bits [21:17] selects the arithmetic. Sub-op 0 adds A and B. Sub-op 1 adds A, B and the carry. Both produce the low 32 bits of the sum, and `carry_next` is the carry out of bit 31.
- R4: Sub-op 2 returns A−B and sets `carry_next` to 1 when A ≥ B unsigned (no borrow). Sub-op 3 returns A−B−1 when the carry is 0 and A−B when it is 1. Its `carry_next` is 1 exactly when that difference is not negative.
- R5: Sub-ops 8, 9, 10, 11 and 12 return A^B, A|B, A&B, A&~B and ~(A&B). They hold the carry (`carry_we`=0, `carry_next`=`carry_q`).
- R6: Any other sub-op value gives `result` 0 and `illegal_op` 1, and leaves the carry unchanged.
- R7: Code 1 returns A plus bits [31:14] sign-extended to 32 bits. The carry is unchanged.
- R8: Code 5 drives `rd_addr` with the low RADDR_W bits of A plus the sign-extended immediate, and returns `rd_data` as the result in the same cycle. The carry is unchanged.
- R9: The field mask is (1<<size)−1, where size is bits [26:22]. Bits [21:17] give the source bit position and bits [31:27] the destination bit position. Code 2 takes B shifted right by the source position and masked. It clears the masked field of A at the destination position and inserts that value there.
- R10: Code 3 returns ((B >> A[4:0]) & mask) << destination position.
- R11: Code 4 returns ((B >> source position) & mask) << A[4:0].
- R12: The carry flag loads `carry_next` on a clock edge with `issue` high and `carry_we` high, and holds otherwise. `carry_we` is 1 only for sub-ops 0 to 3 under code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | The current instruction executes this cycle |
| opcode | input | 32 | Instruction word |
| a | input | 32 | Operand A |
| b | input | 32 | Operand B |
| rd_data | input | 32 | Data returned by the external register file for `rd_addr` |
| result | output | 32 | Combinational result |
| carry_q | output | 1 | Current carry flag |
| carry_next | output | 1 | Carry value the instruction would leave |
| carry_we | output | 1 | The instruction writes the carry |
| rd_addr | output | RADDR_W | Read address for the immediate-offset read |
| illegal_op | output | 1 | Undefined function or sub-operation |

## Verification
Within a single cycle, the carry written by one instruction and the carry read by the next add-with-carry or subtract-with-borrow meet at the flag register. The bench provokes this with directed chains of back-to-back carry operations at the 32-bit boundary. It also interleaves random streams of carry producers, carry consumers, logic ops and illegal codes, with `issue` sometimes low. A bench model keeps its own carry and updates it only on issued carry writes. Every result and every carry output is compared with that model, so any carry lost or updated at the wrong edge shows up in the next consumer.

// File: rtl/bfx_alu_pkg.sv
package bfx_alu_pkg;

    localparam int XLEN    = 32;
    localparam int SHW     = 5;
    localparam int IMM_LSB = 14;
    localparam int IMM_W   = XLEN - IMM_LSB;

    typedef enum logic [2:0] {
        FN_REGOP = 3'd0,
        FN_ADDI  = 3'd1,
        FN_BFINS = 3'd2,
        FN_BFXI  = 3'd3,
        FN_BFXR  = 3'd4,
        FN_RDI   = 3'd5
    } fn_e;

    typedef enum logic [4:0] {
        SUB_ADD  = 5'd0,
        SUB_ADC  = 5'd1,
        SUB_SUB  = 5'd2,
        SUB_SBB  = 5'd3,
        SUB_XOR  = 5'd8,
        SUB_OR   = 5'd9,
        SUB_AND  = 5'd10,
        SUB_ANDN = 5'd11,
        SUB_NAND = 5'd12
    } sub_e;

    // Instruction word layout; the immediate overlaps [31:14].
    typedef struct packed {
        logic [SHW-1:0] dst_pos;   // [31:27]
        logic [SHW-1:0] fsize;     // [26:22]
        logic [SHW-1:0] sel;       // [21:17] sub-op or source position
        logic [13:0]    misc;      // [16:3]
        logic [2:0]     fn;        // [2:0]
    } insn_t;

    typedef struct packed {
        logic [XLEN-1:0] value;
        logic            cout;
        logic            cwe;
        logic            bad;
    } arith_out_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] raw);
        return {{IMM_LSB{raw[IMM_W-1]}}, raw};
    endfunction

    function automatic logic [XLEN-1:0] field_mask(input logic [SHW-1:0] size);
        return (XLEN'(1) << size) - XLEN'(1);
    endfunction

endpackage

// File: rtl/bfx_arith_unit.sv
module bfx_arith_unit
    import bfx_alu_pkg::*;
(
    input  logic [SHW-1:0]  sub_op,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic            cin,
    output arith_out_t      res
);
    logic [XLEN:0] wide;
    logic          borrow_in;

    always_comb begin
        res       = '0;
        res.cout  = cin;
        wide      = '0;
        borrow_in = 1'b0;
        case (sub_e'(sub_op))
            SUB_ADD, SUB_ADC: begin
                wide = {1'b0, opa} + {1'b0, opb}
                     + {{XLEN{1'b0}}, (sub_op[0] & cin)};
                res.value = wide[XLEN-1:0];
                res.cout  = wide[XLEN];
                res.cwe   = 1'b1;
            end
            SUB_SUB, SUB_SBB: begin
                borrow_in = sub_op[0] & ~cin;
                wide = {1'b0, opa} - {1'b0, opb}
                     - {{XLEN{1'b0}}, borrow_in};
                res.value = wide[XLEN-1:0];
                res.cout  = ~wide[XLEN];
                res.cwe   = 1'b1;
            end
            SUB_XOR:  res.value = opa ^ opb;
            SUB_OR:   res.value = opa | opb;
            SUB_AND:  res.value = opa & opb;
            SUB_ANDN: res.value = opa & ~opb;
            SUB_NAND: res.value = ~(opa & opb);
            default:  res.bad   = 1'b1;
        endcase
    end
endmodule

// File: rtl/bfx_field_unit.sv
module bfx_field_unit
    import bfx_alu_pkg::*;
(
    input  fn_e             fn,
    input  logic [SHW-1:0]  src_pos,
    input  logic [SHW-1:0]  fsize,
    input  logic [SHW-1:0]  dst_pos,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic [XLEN-1:0] value
);
    logic [XLEN-1:0] mask;
    logic [SHW-1:0]  rsh;
    logic [SHW-1:0]  lsh;
    logic [XLEN-1:0] fld;

    assign mask = field_mask(fsize);

    always_comb begin
        rsh = src_pos;
        lsh = dst_pos;
        if (fn == FN_BFXI) rsh = opa[SHW-1:0];
        if (fn == FN_BFXR) lsh = opa[SHW-1:0];
        fld = (opb >> rsh) & mask;
        if (fn == FN_BFINS)
            value = (opa & ~(mask << dst_pos)) | (fld << dst_pos);
        else
            value = fld << lsh;
    end
endmodule

// File: rtl/bfx_addr_unit.sv
module bfx_addr_unit
    import bfx_alu_pkg::*;
#(
    parameter int RADDR_W = 12
) (
    input  logic [XLEN-1:0]    opa,
    input  logic [IMM_W-1:0]   imm_raw,
    output logic [XLEN-1:0]    sum,
    output logic [RADDR_W-1:0] addr
);
    logic [XLEN-1:0] unused_hi;

    assign sum       = opa + sext_imm(imm_raw);
    assign addr      = sum[RADDR_W-1:0];
    assign unused_hi = sum >> RADDR_W;
endmodule

// File: rtl/bfx_alu.sv
module bfx_alu
    import bfx_alu_pkg::*;
#(
    parameter int RADDR_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               issue,
    input  logic [XLEN-1:0]    opcode,
    input  logic [XLEN-1:0]    a,
    input  logic [XLEN-1:0]    b,
    input  logic [XLEN-1:0]    rd_data,
    output logic [XLEN-1:0]    result,
    output logic               carry_q,
    output logic               carry_next,
    output logic               carry_we,
    output logic [RADDR_W-1:0] rd_addr,
    output logic               illegal_op
);
    insn_t           ins;
    fn_e             fn;
    arith_out_t      ar;
    logic [XLEN-1:0] fld_val;
    logic [XLEN-1:0] imm_sum;
    logic [13:0]     unused_misc;

    assign ins         = insn_t'(opcode);
    assign fn          = fn_e'(ins.fn);
    assign unused_misc = ins.misc;

    bfx_arith_unit u_arith (
        .sub_op (ins.sel),
        .opa    (a),
        .opb    (b),
        .cin    (carry_q),
        .res    (ar)
    );

    bfx_field_unit u_field (
        .fn      (fn),
        .src_pos (ins.sel),
        .fsize   (ins.fsize),
        .dst_pos (ins.dst_pos),
        .opa     (a),
        .opb     (b),
        .value   (fld_val)
    );

    bfx_addr_unit #(.RADDR_W(RADDR_W)) u_addr (
        .opa     (a),
        .imm_raw (opcode[XLEN-1:IMM_LSB]),
        .sum     (imm_sum),
        .addr    (rd_addr)
    );

    // Result and flag selection
    always_comb begin
        result     = '0;
        carry_we   = 1'b0;
        illegal_op = 1'b0;
        case (fn)
            FN_REGOP: begin
                result     = ar.value;
                carry_we   = ar.cwe;
                illegal_op = ar.bad;
            end
            FN_ADDI:                   result = imm_sum;
            FN_BFINS, FN_BFXI, FN_BFXR: result = fld_val;
            FN_RDI:                    result = rd_data;
            default:                   illegal_op = 1'b1;
        endcase
        carry_next = carry_we ? ar.cout : carry_q;
    end

    // Carry flag
    always_ff @(posedge clk) begin
        if (rst)
            carry_q <= 1'b0;
        else if (issue && carry_we)
            carry_q <= carry_next;
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> !carry_q);

    a_r12_carry_load: assert property (@(posedge clk) disable iff (rst)
        (issue && carry_we) |=> carry_q == $past(carry_next));

    a_r12_carry_hold: assert property (@(posedge clk) disable iff (rst)
        !(issue && carry_we) |=> $stable(carry_q));

    a_r6_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
        illegal_op |-> (result == '0 && !carry_we));

    a_r5_logic_keeps_carry: assert property (@(posedge clk) disable iff (rst)
        (fn == FN_REGOP && ins.sel[3]) |-> (!carry_we && carry_next == carry_q));

    a_r8_read_passthru: assert property (@(posedge clk) disable iff (rst)
        (fn == FN_RDI) |-> (result == rd_data && !illegal_op));

    a_r12_we_only_arith: assert property (@(posedge clk) disable iff (rst)
        carry_we |-> (fn == FN_REGOP && ins.sel < 5'd4));
endmodule

// File: tb/bfx_alu_tb_top.sv
module bfx_alu_tb_top;
    localparam int RW = 12;

    logic          clk = 1'b0;
    logic          rst;
    logic          issue;
    logic [31:0]   opcode, a, b, rd_data;
    logic [31:0]   result;
    logic          carry_q, carry_next, carry_we, illegal_op;
    logic [RW-1:0] rd_addr;

    int  checks   = 0;
    int  failures = 0;
    bit  exp_carry = 1'b0;
    bit  finished  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    // External register file model: contents derived from the address
    assign rd_data = {rd_addr, 20'h0} ^ 32'h5A5A_1234;

    bfx_alu #(.RADDR_W(RW)) dut_i (
        .clk(clk), .rst(rst), .issue(issue), .opcode(opcode),
        .a(a), .b(b), .rd_data(rd_data), .result(result),
        .carry_q(carry_q), .carry_next(carry_next), .carry_we(carry_we),
        .rd_addr(rd_addr), .illegal_op(illegal_op)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_op(input int fn, input int sel,
                                          input int sz, input int dst);
        return {dst[4:0], sz[4:0], sel[4:0], 14'h0, fn[2:0]};
    endfunction

    function automatic logic [31:0] mk_imm(input int fn, input logic [17:0] imm);
        return {imm, 11'h0, fn[2:0]};
    endfunction

    // Reference model
    function automatic void model(input logic [31:0] o, x, y, input bit c,
                                  output logic [31:0] r, output bit cn,
                                  output bit we, output bit ill,
                                  output logic [RW-1:0] ad, output string tag);
        logic [31:0] simm, mask, s;
        logic [32:0] s33;
        logic [4:0]  sel, sz, dst;
        longint      t;
        simm = {{14{o[31]}}, o[31:14]};
        sel = o[21:17]; sz = o[26:22]; dst = o[31:27];
        mask = (32'h1 << sz) - 32'h1;
        r = 0; cn = c; we = 0; ill = 0; ad = '0; tag = "R2";
        case (o[2:0])
            3'd0: begin
                case (sel)
                    5'd0, 5'd1: begin
                        s33 = {1'b0, x} + {1'b0, y} + 33'(sel[0] & c);
                        r = s33[31:0]; cn = s33[32]; we = 1; tag = "R3";
                    end
                    5'd2, 5'd3: begin
                        t = longint'(x) - longint'(y);
                        if (sel == 5'd3 && !c) t = t - 1;
                        r = t[31:0]; cn = (t >= 0); we = 1; tag = "R4";
                    end
                    5'd8:  begin r = x ^ y;    tag = "R5"; end
                    5'd9:  begin r = x | y;    tag = "R5"; end
                    5'd10: begin r = x & y;    tag = "R5"; end
                    5'd11: begin r = x & ~y;   tag = "R5"; end
                    5'd12: begin r = ~(x & y); tag = "R5"; end
                    default: begin ill = 1; tag = "R6"; end
                endcase
            end
            3'd1: begin r = x + simm; tag = "R7"; end
            3'd2: begin
                r = (x & ~(mask << dst)) | (((y >> sel) & mask) << dst);
                tag = "R9";
            end
            3'd3: begin r = ((y >> x[4:0]) & mask) << dst; tag = "R10"; end
            3'd4: begin r = ((y >> sel) & mask) << x[4:0]; tag = "R11"; end
            3'd5: begin
                s = x + simm; ad = s[RW-1:0];
                r = {ad, 20'h0} ^ 32'h5A5A_1234; tag = "R8";
            end
            default: ill = 1;
        endcase
    endfunction

    task automatic step(input logic [31:0] o, x, y, input bit iss);
        logic [31:0]   er;
        bit            ecn, ewe, eill;
        logic [RW-1:0] ead;
        string         tg;
        @(negedge clk);
        opcode = o; a = x; b = y; issue = iss;
        #1;
        chk(carry_q == exp_carry, "R12", "carry_q", 32'(carry_q), 32'(exp_carry));
        model(o, x, y, exp_carry, er, ecn, ewe, eill, ead, tg);
        chk(result == er, tg, "result", result, er);
        chk(illegal_op == eill, tg, "illegal_op", 32'(illegal_op), 32'(eill));
        chk(carry_we == ewe, "R12", "carry_we", 32'(carry_we), 32'(ewe));
        chk(carry_next == ecn, tg, "carry_next", 32'(carry_next), 32'(ecn));
        if (o[2:0] == 3'd5)
            chk(rd_addr == ead, "R8", "rd_addr", 32'(rd_addr), 32'(ead));
        if (iss && ewe) exp_carry = ecn;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; issue = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_carry = 1'b0;
        #1;
        chk(carry_q == 1'b0, "R1", "carry after reset", 32'(carry_q), 32'h0);
    endtask

    initial begin : watchdog
        #(8 * 190000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed;
        int fn_pick, sel;
        seed = 32'd20240611;
        void'($urandom(seed));
        rst = 1'b1; issue = 1'b0; opcode = '0; a = '0; b = '0;
        do_reset();

        // R3: carry chain across 32-bit boundary, consumed back to back
        step(mk_op(0, 0, 0, 0), 32'hFFFF_FFFF, 32'h1, 1'b1);
        step(mk_op(0, 1, 0, 0), 32'h0, 32'h0, 1'b1);
        step(mk_op(0, 1, 0, 0), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
        // R5: logic op keeps the carry; following ADC sees it
        step(mk_op(0, 9, 0, 0), 32'h0F0F_0000, 32'h00F0_F00F, 1'b1);
        step(mk_op(0, 1, 0, 0), 32'h1, 32'h1, 1'b1);
        // R4: subtract no-borrow cases
        step(mk_op(0, 2, 0, 0), 32'd5, 32'd5, 1'b1);
        step(mk_op(0, 2, 0, 0), 32'd3, 32'd5, 1'b1);
        step(mk_op(0, 3, 0, 0), 32'd4, 32'd4, 1'b1);
        step(mk_op(0, 3, 0, 0), 32'd5, 32'd4, 1'b1);
        step(mk_op(0, 3, 0, 0), 32'd0, 32'd0, 1'b1);
        // R12: not issued, carry must hold
        step(mk_op(0, 0, 0, 0), 32'hFFFF_FFFF, 32'h2, 1'b0);
        step(mk_op(0, 1, 0, 0), 32'h10, 32'h20, 1'b1);
        // R6 / R2: illegal sub-op and function codes leave carry
        step(mk_op(0, 0, 0, 0), 32'hFFFF_FFFF, 32'h1, 1'b1);
        step(mk_op(0, 13, 0, 0), 32'h1234, 32'h5678, 1'b1);
        step(mk_op(0, 31, 0, 0), 32'h1, 32'h1, 1'b1);
        step(mk_op(6, 0, 0, 0), 32'h1, 32'h1, 1'b1);
        step(mk_op(7, 0, 0, 0), 32'h1, 32'h1, 1'b1);
        step(mk_op(0, 1, 0, 0), 32'h0, 32'h0, 1'b1);
        // R7: negative and positive immediates
        step(mk_imm(1, 18'h3FFFF), 32'h0000_0010, 32'h0, 1'b1);
        step(mk_imm(1, 18'h1FFFF), 32'h0000_0001, 32'h0, 1'b1);
        step(mk_imm(1, 18'h20000), 32'h0, 32'h0, 1'b1);
        // R8: read address wraps into low bits
        step(mk_imm(5, 18'h3FFFF), 32'h0, 32'h0, 1'b1);
        step(mk_imm(5, 18'h00585), 32'h0000_1000, 32'h0, 1'b1);
        // R9: size 0 returns A, full-width field, top-bit insert
        step(mk_op(2, 3, 0, 7), 32'hDEAD_BEEF, 32'hFFFF_FFFF, 1'b1);
        step(mk_op(2, 0, 31, 0), 32'h8000_0000, 32'hFFFF_FFFF, 1'b1);
        step(mk_op(2, 4, 4, 28), 32'h1234_5678, 32'h0000_00A0, 1'b1);
        // R10 / R11: shift amounts from A low bits
        step(mk_op(3, 0, 8, 4), 32'h0000_0028, 32'hABCD_EF12, 1'b1);
        step(mk_op(3, 0, 0, 4), 32'h0000_0008, 32'hFFFF_FFFF, 1'b1);
        step(mk_op(4, 16, 8, 0), 32'h0000_003C, 32'h00AB_0000, 1'b1);
        step(mk_op(4, 0, 31, 0), 32'h0000_0001, 32'hFFFF_FFFF, 1'b1);

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] o, x, y;
            o = $urandom();
            x = $urandom();
            y = $urandom();
            fn_pick = $urandom_range(0, 9);
            if (fn_pick < 4) begin
                sel = ($urandom_range(0, 3) != 0) ? $urandom_range(0, 3)
                                                  : $urandom_range(4, 31);
                o[2:0] = 3'd0;
                o[21:17] = sel[4:0];
                if ($urandom_range(0, 3) == 0) y = ~x + 32'($urandom_range(0, 2));
            end else begin
                o[2:0] = 3'(fn_pick - 3);
            end
            step(o, x, y, ($urandom_range(0, 7) != 0));
        end

        // R1: reset with carry set clears it
        step(mk_op(0, 0, 0, 0), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
        do_reset();
        step(mk_op(0, 1, 0, 0), 32'h0, 32'h0, 1'b1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule